// File: doc/BRIEF.md
# Class Minimum and Winner Selector

This block is the decision stage of a hyperbox classifier. An upstream array of hyperbox units produces one distance score per hyperbox. A smaller score means the input lies closer to that hyperbox, so it means a higher fuzzy membership. The hyperboxes that hold the same position in every class share one input tap. Because of that, the scores arrive as one slot per clock, and each slot carries one score for every class at once.

For each class, a running comparator keeps the smallest enabled score of the current vector. When the last slot has been taken, the class minima are frozen. A serial arg-min then walks through the classes, one per clock, and reports the winning class index. It also raises a flag when the winning score is shared by more than one class. A one-clock completion strobe marks the moment the label is valid.

Classes that have fewer hyperboxes than the widest class mask their unused slots with per-class enable bits.

Top module: `classWinnerSelect`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `done`, `indeterminate` and `classLabel` are all 0.
- R2: A slot is taken in a cycle where `inValid` is high and no scan is running. The score for class k is `sumVec[k*SUM_W +: SUM_W]`, and that score counts only when `slotEn[k]` is 1. For each class the block keeps the minimum of the enabled scores between a slot with `inFirst`=1 and a slot with `inLast`=1. A slot with `inFirst`=1 discards minima left from earlier vectors. A single slot may carry both `inFirst` and `inLast`.
- R3: A class with no enabled score in a vector scores 2^SUM_W-1, which is all ones.
- R4: `classLabel` is the index of the class with the smallest score.
- R5: When two or more classes share the smallest score, `indeterminate` is 1 and `classLabel` is the lowest of the tied indices. Otherwise `indeterminate` is 0.
- R6: `done` is high for exactly one cycle. That cycle is the (NUM_CLASSES+1)-th cycle after the cycle in which the slot with `inLast`=1 is taken.
- R7: `classLabel` and `indeterminate` keep their values in every cycle until the next `done`.
- R8: Slots presented while a scan is running (from the cycle after the last slot up to the cycle before `done`) are ignored. A new vector may start in the cycle in which `done` is high.
- R9: Cycles with `inValid` low inside a vector are skipped, whatever `sumVec` and `slotEn` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A slot of scores is present |
| inFirst | input | 1 | This slot is the first of a vector |
| inLast | input | 1 | This slot is the last of a vector |
| slotEn | input | NUM_CLASSES | Per-class enable for this slot |
| sumVec | input | NUM_CLASSES*SUM_W | Packed scores, class k at bits k*SUM_W upward |
| classLabel | output | $clog2(NUM_CLASSES) | Winning class index |
| indeterminate | output | 1 | More than one class holds the winning score |
| done | output | 1 | One-clock strobe: label and flag are valid |

## Verification
The hardest case to reach is a slot that arrives while the serial scan is still running. Such a slot must not disturb the frozen class minima. A second vector must still be able to start in the very cycle the strobe is high.

The bench reaches this case in two ways. First, it drives slots with zero scores, every enable bit set and both first and last flags raised, in every scan cycle. Second, it chains a vector directly behind a `done`, and the values of that vector would change the winner if stale minima survived. Ties are created in two arrangements: three classes sharing the minimum, and an early tie that a later, smaller class clears.

// File: rtl/cwsel_pkg.sv
package cwsel_pkg;

  // Strobes issued by the sequencer to the datapath each cycle.
  typedef struct packed {
    logic takeSlot;   // fold the current slot into the class minima
    logic takeFirst;  // current slot opens a new vector
    logic scanStep;   // examine one class in the arg-min walk
    logic scanFirst;  // first class of the walk
    logic publish;    // last class of the walk: update outputs
  } selStrobe_t;

  function automatic int lblWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/classMinUnit.sv
module classMinUnit #(
  parameter int SUM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             takeSlot,
  input  logic             takeFirst,
  input  logic             slotEn,
  input  logic [SUM_W-1:0] sumIn,
  output logic [SUM_W-1:0] minOut
);

  logic [SUM_W-1:0] minReg;

  // Running minimum over enabled slots; an empty class stays all ones.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      minReg <= '1;
    end else if (takeSlot) begin
      if (takeFirst) begin
        minReg <= slotEn ? sumIn : '1;
      end else if (slotEn && (sumIn < minReg)) begin
        minReg <= sumIn;
      end
    end
  end

  assign minOut = minReg;

  AST_MIN_NONINC: assert property (@(posedge clk) disable iff (!rstN)
    (takeSlot && !takeFirst) |=> (minOut <= $past(minOut))) else $error("min rose"); // R2
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (takeSlot && slotEn) |=> (minOut <= $past(sumIn))) else $error("min above score"); // R2
  AST_MIN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !takeSlot |=> $stable(minOut)) else $error("min moved without slot"); // R9

endmodule

// File: rtl/cwselCtl.sv
module cwselCtl
  import cwsel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int LBL_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inFirst,
  input  logic             inLast,
  output selStrobe_t       strobe,
  output logic [LBL_W-1:0] scanIdx
);

  localparam logic [LBL_W-1:0] LAST_IDX = LBL_W'(NUM_CLASSES - 1);

  typedef enum logic {ST_COLLECT, ST_SCAN} ctlState_t;

  ctlState_t        state;
  logic [LBL_W-1:0] idx;

  always_comb begin
    strobe           = '0;
    strobe.takeSlot  = (state == ST_COLLECT) && inValid;
    strobe.takeFirst = inFirst;
    strobe.scanStep  = (state == ST_SCAN);
    strobe.scanFirst = (state == ST_SCAN) && (idx == '0);
    strobe.publish   = (state == ST_SCAN) && (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_COLLECT;
      idx   <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (inValid && inLast) begin
            state <= ST_SCAN;
            idx   <= '0;
          end
        end
        default: begin
          if (idx == LAST_IDX) begin
            state <= ST_COLLECT;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  assign scanIdx = idx;

  AST_SCAN_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (idx <= LAST_IDX)) else $error("scan index out of range"); // R4
  AST_SCAN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && idx == LAST_IDX) |=> (state == ST_COLLECT)) else $error("scan overran"); // R6
  AST_SCAN_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COLLECT && inValid && inLast) |=> (state == ST_SCAN && idx == '0)) else $error("scan not started"); // R6
  AST_NO_TAKE_IN_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> !strobe.takeSlot) else $error("slot taken during scan"); // R8

endmodule

// File: rtl/cwselDp.sv
module cwselDp
  import cwsel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int SUM_W       = 12,
  parameter int LBL_W       = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  selStrobe_t                   strobe,
  input  logic [LBL_W-1:0]             scanIdx,
  input  logic [NUM_CLASSES-1:0]       slotEn,
  input  logic [NUM_CLASSES*SUM_W-1:0] sumVec,
  output logic [LBL_W-1:0]             classLabel,
  output logic                         indeterminate,
  output logic                         done
);

  logic [SUM_W-1:0] classMin [NUM_CLASSES];

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
    classMinUnit #(.SUM_W(SUM_W)) u_min (
      .clk      (clk),
      .rstN     (rstN),
      .takeSlot (strobe.takeSlot),
      .takeFirst(strobe.takeFirst),
      .slotEn   (slotEn[k]),
      .sumIn    (sumVec[k*SUM_W +: SUM_W]),
      .minOut   (classMin[k])
    );
  end

  // Serial arg-min state
  logic [SUM_W-1:0] bestVal, nxtVal, curVal;
  logic [LBL_W-1:0] bestIdx, nxtIdx;
  logic             bestTie, nxtTie;

  assign curVal = classMin[scanIdx];

  always_comb begin
    nxtVal = bestVal;
    nxtIdx = bestIdx;
    nxtTie = bestTie;
    if (strobe.scanFirst) begin
      nxtVal = curVal;
      nxtIdx = scanIdx;
      nxtTie = 1'b0;
    end else if (curVal < bestVal) begin
      nxtVal = curVal;
      nxtIdx = scanIdx;
      nxtTie = 1'b0;
    end else if (curVal == bestVal) begin
      nxtTie = 1'b1;   // keep the lower index already held
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestVal       <= '1;
      bestIdx       <= '0;
      bestTie       <= 1'b0;
      classLabel    <= '0;
      indeterminate <= 1'b0;
      done          <= 1'b0;
    end else begin
      done <= strobe.publish;
      if (strobe.scanStep) begin
        bestVal <= nxtVal;
        bestIdx <= nxtIdx;
        bestTie <= nxtTie;
      end
      if (strobe.publish) begin
        classLabel    <= nxtIdx;
        indeterminate <= nxtTie;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R6
  AST_LABEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(classLabel) < NUM_CLASSES)) else $error("label out of range"); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> ($stable(classLabel) && $stable(indeterminate)) || done) else $error("outputs moved"); // R7
  AST_BEST_NOT_WORSE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.scanStep && !strobe.scanFirst) |=> (bestVal <= $past(bestVal))) else $error("best rose"); // R4

endmodule

// File: rtl/classWinnerSelect.sv
module classWinnerSelect
  import cwsel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int SUM_W       = 12,
  parameter int LBL_W       = lblWidth(NUM_CLASSES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic                         inFirst,
  input  logic                         inLast,
  input  logic [NUM_CLASSES-1:0]       slotEn,
  input  logic [NUM_CLASSES*SUM_W-1:0] sumVec,
  output logic [LBL_W-1:0]             classLabel,
  output logic                         indeterminate,
  output logic                         done
);

  selStrobe_t       strobe;
  logic [LBL_W-1:0] scanIdx;

  cwselCtl #(.NUM_CLASSES(NUM_CLASSES), .LBL_W(LBL_W)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inFirst(inFirst),
    .inLast (inLast),
    .strobe (strobe),
    .scanIdx(scanIdx)
  );

  cwselDp #(.NUM_CLASSES(NUM_CLASSES), .SUM_W(SUM_W), .LBL_W(LBL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .scanIdx      (scanIdx),
    .slotEn       (slotEn),
    .sumVec       (sumVec),
    .classLabel   (classLabel),
    .indeterminate(indeterminate),
    .done         (done)
  );

endmodule

// File: tb/sim_classWinnerSelect.sv
module sim_classWinnerSelect;
  localparam int CLK_P = 10;
  localparam int K     = 4;
  localparam int W     = 12;
  localparam int LW    = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [K-1:0]   slotEn = '0;
  logic [K*W-1:0] sumVec = '0;
  logic [LW-1:0]  classLabel;
  logic           indeterminate, done;

  int nChk = 0, nFail = 0;
  logic [W-1:0] vS [0:7][0:3];
  logic         vE [0:7][0:3];
  int expLbl, expTie;

  always #(CLK_P/2) clk = ~clk;

  classWinnerSelect #(.NUM_CLASSES(K), .SUM_W(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .slotEn(slotEn), .sumVec(sumVec), .classLabel(classLabel),
    .indeterminate(indeterminate), .done(done)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic clearVec();
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < K; k++) begin
        vS[j][k] = '0;
        vE[j][k] = 1'b0;
      end
  endtask

  task automatic setSlot(input int j, input int a, input int b, input int c, input int d);
    vS[j][0] = W'(a); vS[j][1] = W'(b); vS[j][2] = W'(c); vS[j][3] = W'(d);
    for (int k = 0; k < K; k++) vE[j][k] = 1'b1;
  endtask

  // Expected result from R2..R5
  task automatic calcExp(input int n);
    int mins [K];
    int best, cnt;
    for (int k = 0; k < K; k++) begin
      mins[k] = (1 << W) - 1;
      for (int j = 0; j < n; j++)
        if (vE[j][k] && int'(vS[j][k]) < mins[k]) mins[k] = int'(vS[j][k]);
    end
    best = mins[0]; expLbl = 0;
    for (int k = 1; k < K; k++)
      if (mins[k] < best) begin best = mins[k]; expLbl = k; end
    cnt = 0;
    for (int k = 0; k < K; k++) if (mins[k] == best) cnt++;
    expTie = (cnt > 1) ? 1 : 0;
  endtask

  task automatic noiseIn();
    inValid = 1'b1; inFirst = 1'b1; inLast = 1'b1; slotEn = '1; sumVec = '0;
  endtask

  task automatic idleIn();
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
  endtask

  task automatic runVec(input string r, input int n, input bit gap, input bit noise, input bit chain);
    int cnt;
    calcExp(n);
    for (int j = 0; j < n; j++) begin
      inValid = 1'b1; inFirst = (j == 0); inLast = (j == n - 1);
      for (int k = 0; k < K; k++) begin
        sumVec[k*W +: W] = vS[j][k];
        slotEn[k] = vE[j][k];
      end
      @(negedge clk);
      if (gap && j < n - 1) begin
        noiseIn(); inValid = 1'b0;   // R9: skipped cycle with small scores
        @(negedge clk);
      end
    end
    idleIn();
    cnt = 1;
    chk("R6", "done after last slot", int'(done), 0);
    while (!done && cnt < 40) begin
      if (noise) noiseIn();          // R8: slots during scan
      @(negedge clk);
      idleIn();
      cnt++;
    end
    chk("R6", "latency", cnt, K + 1);
    chk(r, "label", int'(classLabel), expLbl);
    chk(r, "indeterminate", int'(indeterminate), expTie);
    if (!chain) begin
      @(negedge clk);
      chk("R6", "done pulse width", int'(done), 0);
      chk("R7", "label held", int'(classLabel), expLbl);
    end
  endtask

  task automatic loadBasic();
    clearVec();
    setSlot(0, 500, 800, 400, 1000);
    setSlot(1, 300, 900, 410, 999);
    setSlot(2, 700, 260, 420, 998);
  endtask

  task automatic loadTie();
    clearVec();
    setSlot(0, 600, 150, 800, 150);
    setSlot(1, 700, 900, 150, 151);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "label in reset", int'(classLabel), 0);
    chk("R1", "indeterminate in reset", int'(indeterminate), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "label after reset", int'(classLabel), 0);
  endtask

  task automatic testBasic();  // R2 R4
    loadBasic();
    runVec("R4", 3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testTie();    // R5 three-way tie, lowest index wins
    loadTie();
    runVec("R5", 2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testTieCleared();  // R5 tie cleared by later class, R2 single slot
    clearVec();
    setSlot(0, 200, 200, 100, 300);
    runVec("R5", 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testMask();   // R2 disabled smaller score ignored
    clearVec();
    setSlot(0, 100, 500, 500, 400);
    setSlot(1, 900, 500, 500, 5);
    vE[1][3] = 1'b0;
    setSlot(2, 150, 500, 500, 400);
    vS[2][1] = 1; vE[2][1] = 1'b0;
    runVec("R2", 3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testEmpty();  // R3
    clearVec();
    vS[0][3] = 12'd4094; vE[0][3] = 1'b1;
    vS[0][0] = 12'd1;
    runVec("R3", 1, 1'b0, 1'b0, 1'b0);
    clearVec();
    vS[0][1] = 12'd2;
    runVec("R3", 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testGap();    // R9
    loadBasic();
    runVec("R9", 3, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testScanNoise();  // R8
    loadTie();
    runVec("R8", 2, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testChain();  // R8 start in done cycle, R2 restart on first slot
    loadBasic();
    runVec("R8", 3, 1'b0, 1'b0, 1'b1);
    clearVec();
    setSlot(0, 3000, 2900, 2500, 2600);
    runVec("R2", 1, 1'b0, 1'b0, 1'b0);
    chk("R2", "restart winner", int'(classLabel), 2);
  endtask

  task automatic testHold();   // R7
    loadTie();
    runVec("R5", 2, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 6; c++) begin
      inValid = 1'b0; slotEn = '1; sumVec = '0; inFirst = 1'b1;
      @(negedge clk);
      chk("R7", "label hold", int'(classLabel), 1);
      chk("R7", "indeterminate hold", int'(indeterminate), 1);
    end
    idleIn();
  endtask

  initial begin
    #(CLK_P * 100000);
    nChk++; nFail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testBasic();
    testTie();
    testTieCleared();
    testMask();
    testEmpty();
    testGap();
    testScanNoise();
    testChain();
    testHold();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule